// File: doc/BRIEF.md
# Linked-Block Configuration Stream Parser

This block takes a configuration stream one byte per valid strobe and turns it into register writes into a banked byte memory. It discards filler bytes until a synchronisation byte appears. It then reads a device identifier and a control byte. After those it walks a chain of variable-length data blocks. Each block names its own bank and start address. A flag in each block header says whether another block follows it.

Each data byte produces a one-cycle write strobe with its bank, address and data. A frame that closes correctly produces a one-cycle done pulse. A broken end marker sets a sticky framing error. If the identifier does not match the programmed one, the frame is still parsed, but it writes nothing and signals nothing.

Top module: `cfg_stream_parser`

## Requirements
- R1: After reset, `wr_en`, `done` and `frame_err` are low and the parser is hunting for the sync byte.
- R2: While hunting, every byte other than 0xD5 is dropped without any write. A 0xD5 byte makes the next byte the identifier and the byte after that the control byte. The control byte has no effect.
- R3: If the identifier byte differs from `dev_id`, the frame is parsed as usual, but no write strobe and no done pulse come out of it.
- R4: In a block header, bits [ADDR_W-1:0] are the start address, bit 6 set means another block follows, and bit 7 set turns on end-marker checking for that block. Other bits are ignored.
- R5: The header is followed by a bank byte (low BANK_W bits used) and a count byte. Each following data byte gives `wr_en` high for one cycle, in the cycle after the byte is accepted. The writes go to consecutive addresses from the start address, wrapping modulo 2^ADDR_W.
- R6: A count of zero produces no writes, and the next byte is taken as the end marker.
- R7: With checking on, an end byte other than 0x2A sets `frame_err`, returns the parser to sync hunting, and gives no done pulse.
- R8: With checking off, any byte in the end-marker position is accepted as a correct end.
- R9: After a correct end, a block with the follow flag set makes the next byte a new header. A block with the flag clear gives a one-cycle `done` pulse in the next cycle, and the parser hunts again, so a trailing filler byte is ignored.
- R10: A cycle with `byte_vld` low changes nothing and produces no write or done.
- R11: `frame_err` stays high until reset, including through later correct frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_vld | input | 1 | Stream byte valid strobe |
| byte_in | input | 8 | Stream byte |
| dev_id | input | 8 | Programmed device identifier |
| wr_en | output | 1 | Register write strobe |
| wr_bank | output | BANK_W | Write bank |
| wr_addr | output | ADDR_W | Write byte address |
| wr_data | output | 8 | Write data |
| frame_err | output | 1 | Sticky framing error |
| done | output | 1 | Frame complete pulse |

## Verification
The hardest case to reach is the interaction of several things at once: address wrap inside a block, a zero-length block, and gaps in the valid strobe, all inside a multi-block chain. Reaching them needs exact frame construction. The stimulus builds frames byte by byte, with a header starting at address 30, an empty block and randomly placed idle cycles. A behavioural reference model checks every cycle of it. A separate frame with checking disabled and a wrong end byte, followed by one with checking enabled and a wrong end byte, separates R8 from R7. A correct frame sent after the error confirms that the flag stays set.

// File: rtl/cfg_stream_parser.sv
module cfg_stream_parser #(
  parameter int ADDR_W = 5,
  parameter int BANK_W = 2,
  parameter logic [7:0] SYNC_BYTE = 8'hD5,
  parameter logic [7:0] END_BYTE = 8'h2A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_vld,
  input  logic [7:0]        byte_in,
  input  logic [7:0]        dev_id,
  output logic              wr_en,
  output logic [BANK_W-1:0] wr_bank,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              frame_err,
  output logic              done
);
  localparam int FOLLOW_BIT = 6;
  localparam int CHECK_BIT  = 7;

  typedef enum logic [2:0] {
    S_HUNT, S_ID, S_CTRL, S_HDR, S_BANK, S_CNT, S_DATA, S_END
  } st_t;

  st_t               st;
  logic [ADDR_W-1:0] ptr;
  logic [BANK_W-1:0] bank_q;
  logic [7:0]        left;
  logic              more, chk, own;

  wire end_bad = chk && (byte_in != END_BYTE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_HUNT;
      ptr       <= '0;
      bank_q    <= '0;
      left      <= '0;
      more      <= 1'b0;
      chk       <= 1'b0;
      own       <= 1'b0;
      wr_en     <= 1'b0;
      wr_bank   <= '0;
      wr_addr   <= '0;
      wr_data   <= '0;
      frame_err <= 1'b0;
      done      <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      done  <= 1'b0;
      if (byte_vld) begin
        case (st)
          S_HUNT: if (byte_in == SYNC_BYTE) st <= S_ID;
          S_ID: begin
            own <= (byte_in == dev_id);
            st  <= S_CTRL;
          end
          S_CTRL: st <= S_HDR;
          S_HDR: begin
            ptr  <= byte_in[ADDR_W-1:0];
            more <= byte_in[FOLLOW_BIT];
            chk  <= byte_in[CHECK_BIT];
            st   <= S_BANK;
          end
          S_BANK: begin
            bank_q <= byte_in[BANK_W-1:0];
            st     <= S_CNT;
          end
          S_CNT: begin
            left <= byte_in;
            st   <= (byte_in == 8'd0) ? S_END : S_DATA;
          end
          S_DATA: begin
            wr_en   <= own;
            wr_addr <= ptr;
            wr_bank <= bank_q;
            wr_data <= byte_in;
            ptr     <= ptr + 1'b1;
            left    <= left - 8'd1;
            if (left == 8'd1) st <= S_END;
          end
          S_END: begin
            if (end_bad) begin
              frame_err <= 1'b1;
              st        <= S_HUNT;
            end else if (more) begin
              st <= S_HDR;
            end else begin
              done <= own;
              st   <= S_HUNT;
            end
          end
          default: st <= S_HUNT;
        endcase
      end
    end
  end
endmodule

module cfg_stream_parser_chk #(
  parameter int ADDR_W = 5,
  parameter int BANK_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              byte_vld,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [BANK_W-1:0] wr_bank,
  input logic              frame_err,
  input logic              done
);
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !wr_en);

  assert_err_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> frame_err);

  assert_err_no_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_err) |-> !done);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_vld |=> !wr_en && !done);

  assert_idle_no_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_vld |=> $stable(frame_err));

  assert_fields_known_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !$isunknown({wr_addr, wr_bank}));
endmodule

bind cfg_stream_parser cfg_stream_parser_chk #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .wr_en(wr_en),
  .wr_addr(wr_addr), .wr_bank(wr_bank), .frame_err(frame_err), .done(done)
);

// File: tb/test_cfg_stream_parser.sv
`timescale 1ns/1ps
module test_cfg_stream_parser;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       byte_vld = 1'b0;
  logic [7:0] byte_in = 8'h00;
  logic [7:0] dev_id = 8'h01;
  logic       wr_en, frame_err, done;
  logic [1:0] wr_bank;
  logic [4:0] wr_addr;
  logic [7:0] wr_data;

  int checks = 0, fails = 0;
  bit gaps = 1'b0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  cfg_stream_parser i_cfg_stream_parser (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_in(byte_in),
    .dev_id(dev_id), .wr_en(wr_en), .wr_bank(wr_bank), .wr_addr(wr_addr),
    .wr_data(wr_data), .frame_err(frame_err), .done(done)
  );

  // behavioural reference: position within the frame grammar
  int phase, m_addr, m_bank, m_left;
  bit m_more, m_chk, m_mine;
  bit e_wr, e_done, e_err;
  int e_addr, e_bank, e_data;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase = 0; e_wr = 0; e_done = 0; e_err = 0;
      m_addr = 0; m_bank = 0; m_left = 0; m_more = 0; m_chk = 0; m_mine = 0;
      e_addr = 0; e_bank = 0; e_data = 0;
    end else begin
      e_wr = 0; e_done = 0;
      if (byte_vld) begin
        if (phase == 0) begin
          if (byte_in == 8'hD5) phase = 1;
        end else if (phase == 1) begin
          m_mine = (byte_in == dev_id); phase = 2;
        end else if (phase == 2) phase = 3;
        else if (phase == 3) begin
          m_addr = byte_in % 32; m_more = byte_in[6]; m_chk = byte_in[7]; phase = 4;
        end else if (phase == 4) begin
          m_bank = byte_in % 4; phase = 5;
        end else if (phase == 5) begin
          m_left = byte_in; phase = (m_left == 0) ? 7 : 6;
        end else if (phase == 6) begin
          if (m_mine) begin
            e_wr = 1; e_addr = m_addr; e_bank = m_bank; e_data = byte_in;
          end
          m_addr = (m_addr + 1) % 32;
          m_left = m_left - 1;
          if (m_left == 0) phase = 7;
        end else begin
          if (m_chk && byte_in != 8'h2A) begin
            e_err = 1; phase = 0;
          end else if (m_more) phase = 3;
          else begin
            e_done = m_mine; phase = 0;
          end
        end
      end
    end
  end

  always @(negedge clk) if (rst_n && !finished) begin
    checks++;
    if (wr_en !== e_wr) begin
      fails++; $display("FAIL R5 wr_en got %0b exp %0b at %0t", wr_en, e_wr, $time);
    end else if (e_wr) begin
      checks++;
      if (wr_addr !== e_addr[4:0] || wr_bank !== e_bank[1:0] || wr_data !== e_data[7:0]) begin
        fails++;
        $display("FAIL R5 write got b%0d a%0d d%02h exp b%0d a%0d d%02h",
                 wr_bank, wr_addr, wr_data, e_bank, e_addr, e_data);
      end
    end
    checks++;
    if (done !== e_done) begin
      fails++; $display("FAIL R9 done got %0b exp %0b at %0t", done, e_done, $time);
    end
    checks++;
    if (frame_err !== e_err) begin
      fails++; $display("FAIL R7 frame_err got %0b exp %0b at %0t", frame_err, e_err, $time);
    end
  end

  task automatic put(input logic [7:0] b);
    byte_vld = 1'b1; byte_in = b;
    @(negedge clk);
    byte_vld = 1'b0; byte_in = 8'h5A;
    if (gaps) repeat ($urandom_range(0, 2)) @(negedge clk);
  endtask

  task automatic block(input logic [7:0] hdr, input logic [7:0] bk,
                       input int n, input logic [7:0] seed, input logic [7:0] tail);
    put(hdr); put(bk); put(n[7:0]);
    for (int i = 0; i < n; i++) put(seed + 8'(i * 17));
    put(tail);
  endtask

  task automatic head(input logic [7:0] id);
    put(8'h00); put(8'h00); put(8'h37); put(8'hD5); put(id); put(8'hC1);
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if (wr_en !== 1'b0 || done !== 1'b0 || frame_err !== 1'b0) begin
      fails++; $display("FAIL R1 reset got %0b%0b%0b exp 000", wr_en, done, frame_err);
    end
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    $urandom(7);
    do_reset();
    // R2 R4 R5 R9: chained frame, filler and noise ahead of sync
    head(8'h01);
    block(8'hCE, 8'h00, 4, 8'h51, 8'h2A);
    block(8'hDF, 8'h01, 1, 8'hFF, 8'h2A);
    block(8'h91, 8'h02, 3, 8'hF0, 8'h2A);
    put(8'h00); put(8'h00);
    // R5 R6 R10: address wrap, empty block, idle gaps, bank upper bits ignored
    gaps = 1'b1;
    head(8'h01);
    block(8'hFE, 8'h07, 3, 8'h10, 8'h2A);
    block(8'hC3, 8'h01, 0, 8'h00, 8'h2A);
    block(8'h85, 8'h03, 2, 8'h77, 8'h2A);
    put(8'h00);
    // R3: foreign identifier, no writes and no done
    head(8'h07);
    block(8'hC2, 8'h01, 2, 8'h33, 8'h2A);
    block(8'h82, 8'h00, 1, 8'h44, 8'h2A);
    repeat (3) @(negedge clk);
    // R8: checking off, wrong end byte accepted
    head(8'h01);
    block(8'h04, 8'h02, 2, 8'h90, 8'h13);
    // R7: checking on, wrong end byte, then parser hunts again
    head(8'h01);
    block(8'hC8, 8'h01, 1, 8'h66, 8'h2B);
    put(8'h02); put(8'h00);
    // R11: later good frame leaves the error standing
    head(8'h01);
    block(8'h89, 8'h00, 2, 8'hA0, 8'h2A);
    repeat (3) @(negedge clk);
    gaps = 1'b0;
    do_reset();
    head(8'h01);
    block(8'h80, 8'h01, 1, 8'h01, 8'h2A);
    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule